// File: doc/BRIEF.md
# Vector Remap and Abort Decoder

This block sits between the processor bus and the memory slaves. Every access presents an address and a flag that tells an instruction fetch from a data access. The block returns three things: which slave the access belongs to, the address that slave should see, and whether the access must be aborted. The abort is a prefetch abort for a fetch and a data abort for a data access.

The lowest 64 bytes of the address space form an exception-vector window. This window is aliased according to a two-bit mapping mode held in a small register. In boot mode the window points at the start of the 8 KB boot block, which lies just under the 2 GB mark. In flash mode the window is left alone, so it reads flash. In RAM mode the window points at the bottom of SRAM. Reset always puts the block in boot mode.

The rest of the address space is decoded into flash, SRAM, boot block, and two peripheral spaces, each peripheral space having 128 slots of 16 KB. An access to any hole in the map raises an abort. A fetch from peripheral space also raises an abort.

Top module: `vecmap_decoder`

## Requirements
- R1: Reset sets the mapping mode to boot (00). After reset, and before any mode write, address 0x0 decodes to the boot block.
- R2: In boot mode, addresses 0x00–0x3F select the boot block (select code 3). The output address is 0x7FFF_E000 plus the offset.
- R3: In flash mode (01), addresses 0x00–0x3F select flash (select code 1). The address passes through unchanged.
- R4: In RAM mode (10), addresses 0x00–0x3F select SRAM (select code 2). The output address is 0x4000_0000 plus the offset.
- R5: A write with mode_we high updates the mode at the next clock edge. The new mode governs decoding from then on. A write of the reserved encoding 11 leaves the mode unchanged.
- R6: Addresses from 0x40 upward are never remapped, in any mode. The boot block and SRAM stay reachable at their own addresses while they are aliased into the window.
- R7: Outside the window the regions decode as follows, with the address passed through unchanged:
  - 0x0000_0000–0x0001_FFFF selects flash (code 1).
  - 0x4000_0000 up to the configured SRAM size (default 16 KB) selects SRAM (code 2).
  - 0x7FFF_E000–0x7FFF_FFFF selects the boot block (code 3).
  - Assigned slots in 0xE000_0000–0xE01F_FFFF select peripheral space A (code 4).
  - Assigned slots at 0xFFE0_0000 and above select peripheral space B (code 5).
- R8: An address in no region (the gaps between the memories, 0x8000_0000–0xDFFF_FFFF, 0xE020_0000–0xFFDF_FFFF) raises an abort with select code 0. A fetch raises pabort_o; a data access raises dabort_o.
- R9: A data access anywhere inside an assigned 16 KB peripheral slot does not abort, whatever the offset. A fetch from any peripheral address raises pabort_o with select code 0.
- R10: An access to a peripheral slot not set in the slot map aborts, with the kind chosen as in R8. In the default map, space A assigns slots 0–5, 7–11, 23 and 127, and space B assigns slot 127. The slot number is address bits 20:14.
- R11: pabort_o and dabort_o are never high together. dabort_o is never high for a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mode register |
| rst_n | input | 1 | Asynchronous active-low reset; forces boot mode |
| mode_we | input | 1 | Write strobe for the mapping mode |
| mode_wdata | input | 2 | New mode: 00 boot, 01 flash, 10 RAM, 11 reserved |
| addr_i | input | 32 | Bus address of the current access |
| fetch_i | input | 1 | High for an instruction fetch, low for a data access |
| sel_o | output | 3 | Slave select: 0 none, 1 flash, 2 SRAM, 3 boot, 4 peripheral A, 5 peripheral B |
| addr_o | output | 32 | Address presented to the selected slave |
| pabort_o | output | 1 | Prefetch abort |
| dabort_o | output | 1 | Data abort |

## Verification
The assertions check several rules on every clock edge:
- The mode register never holds the reserved code, and a reserved write leaves it stable.
- The two abort flags never rise together, and no data abort appears for a fetch.
- An aborted access never selects a slave, and no fetch ever selects peripheral space.
- Whenever the window is aliased, the region decoder agrees with the current mode.

The exact region edges, the slot map, the aliasing of boot block and SRAM at their own addresses, and the return to boot mode after a mid-run reset depend on chosen addresses and sequences. Only the bench's directed scenarios show those.

// File: rtl/vm_pkg.sv
package vm_pkg;

  typedef enum logic [1:0] {
    MAP_BOOT  = 2'b00,
    MAP_FLASH = 2'b01,
    MAP_RAM   = 2'b10,
    MAP_RSVD  = 2'b11
  } map_mode_e;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_FLASH = 3'd1,
    SEL_SRAM  = 3'd2,
    SEL_BOOT  = 3'd3,
    SEL_PERA  = 3'd4,
    SEL_PERB  = 3'd5
  } slave_e;

  localparam logic [31:0] FLASH_BASE = 32'h0000_0000;
  localparam logic [31:0] SRAM_BASE  = 32'h4000_0000;
  localparam logic [31:0] BOOT_BASE  = 32'h7FFF_E000;
  localparam logic [31:0] PERA_BASE  = 32'hE000_0000;
  localparam logic [31:0] PERB_BASE  = 32'hFFE0_0000;
  localparam logic [32:0] BOOT_BYTES = 33'd8192;
  localparam logic [32:0] PER_BYTES  = 33'h20_0000;
  localparam int          WIN_BITS   = 6;

  // true when base <= a < base + bytes, computed without wrap
  function automatic logic in_span(input logic [31:0] a,
                                   input logic [31:0] base,
                                   input logic [32:0] bytes);
    logic [32:0] ax, bx;
    ax = {1'b0, a};
    bx = {1'b0, base};
    return (ax >= bx) && (ax < bx + bytes);
  endfunction

  // 16 KB slot index inside a 2 MB peripheral space
  function automatic logic [6:0] slot_of(input logic [31:0] a);
    return a[20:14];
  endfunction

  // address the window resolves to under a given mode
  function automatic logic [31:0] win_target(input map_mode_e m,
                                             input logic [31:0] a);
    logic [31:0] off;
    off = {{(32-WIN_BITS){1'b0}}, a[WIN_BITS-1:0]};
    case (m)
      MAP_BOOT: return BOOT_BASE | off;
      MAP_RAM:  return SRAM_BASE | off;
      default:  return a;
    endcase
  endfunction

endpackage

// File: rtl/vm_mode_reg.sv
module vm_mode_reg
  import vm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  logic [1:0] wdata,
  output map_mode_e mode
);

  logic wr_take;
  assign wr_take = we && (wdata != MAP_RSVD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode <= MAP_BOOT;
    else if (wr_take) mode <= map_mode_e'(wdata);
  end

  p_rsvd_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata == MAP_RSVD) |=> $stable(mode));

  p_mode_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode != MAP_RSVD);

endmodule

// File: rtl/vm_window_xlat.sv
module vm_window_xlat
  import vm_pkg::*;
(
  input  map_mode_e   mode,
  input  logic [31:0] addr_i,
  output logic        remap_act,
  output logic [31:0] xlat_addr
);

  logic in_win;

  always_comb begin
    in_win    = (addr_i[31:WIN_BITS] == '0);
    remap_act = in_win && (mode == MAP_BOOT || mode == MAP_RAM);
    xlat_addr = in_win ? win_target(mode, addr_i) : addr_i;
  end

endmodule

// File: rtl/vm_region_dec.sv
module vm_region_dec
  import vm_pkg::*;
#(
  parameter int           SRAM_KB   = 16,
  parameter int           FLASH_KB  = 128,
  parameter logic [127:0] PERA_MAP  = 128'h0,
  parameter logic [127:0] PERB_MAP  = 128'h0
) (
  input  logic [31:0] addr,
  input  logic        fetch,
  output slave_e      sel,
  output logic        pabort,
  output logic        dabort
);

  localparam logic [32:0] SRAM_BYTES  = 33'(SRAM_KB)  * 33'd1024;
  localparam logic [32:0] FLASH_BYTES = 33'(FLASH_KB) * 33'd1024;

  logic hit_flash, hit_sram, hit_boot, hit_pera, hit_perb;
  logic slot_ok, bad_region;
  logic [6:0] slot;

  always_comb begin
    slot      = slot_of(addr);
    hit_flash = in_span(addr, FLASH_BASE, FLASH_BYTES);
    hit_sram  = in_span(addr, SRAM_BASE, SRAM_BYTES);
    hit_boot  = in_span(addr, BOOT_BASE, BOOT_BYTES);
    hit_pera  = in_span(addr, PERA_BASE, PER_BYTES);
    hit_perb  = in_span(addr, PERB_BASE, PER_BYTES);
    slot_ok   = (hit_pera && PERA_MAP[slot]) || (hit_perb && PERB_MAP[slot]);
    bad_region = !(hit_flash || hit_sram || hit_boot || slot_ok);

    sel    = SEL_NONE;
    pabort = 1'b0;
    dabort = 1'b0;
    if (bad_region) begin
      pabort = fetch;
      dabort = !fetch;
    end else if (slot_ok && fetch) begin
      pabort = 1'b1;
    end else if (hit_flash) sel = SEL_FLASH;
    else if (hit_sram)      sel = SEL_SRAM;
    else if (hit_boot)      sel = SEL_BOOT;
    else if (hit_pera)      sel = SEL_PERA;
    else                    sel = SEL_PERB;
  end

endmodule

// File: rtl/vecmap_decoder.sv
module vecmap_decoder
  import vm_pkg::*;
#(
  parameter int           SRAM_KB  = 16,
  parameter int           FLASH_KB = 128,
  parameter logic [127:0] PERA_MAP = (128'h1 << 127) | (128'h1 << 23) | 128'h0FBF,
  parameter logic [127:0] PERB_MAP = (128'h1 << 127)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_we,
  input  logic [1:0]  mode_wdata,
  input  logic [31:0] addr_i,
  input  logic        fetch_i,
  output logic [2:0]  sel_o,
  output logic [31:0] addr_o,
  output logic        pabort_o,
  output logic        dabort_o
);

  map_mode_e   mode;
  logic        remap_act;
  logic [31:0] xlat_addr;
  slave_e      sel;

  vm_mode_reg u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mode_we),
    .wdata (mode_wdata),
    .mode  (mode)
  );

  vm_window_xlat u_win (
    .mode      (mode),
    .addr_i    (addr_i),
    .remap_act (remap_act),
    .xlat_addr (xlat_addr)
  );

  vm_region_dec #(
    .SRAM_KB  (SRAM_KB),
    .FLASH_KB (FLASH_KB),
    .PERA_MAP (PERA_MAP),
    .PERB_MAP (PERB_MAP)
  ) u_dec (
    .addr   (xlat_addr),
    .fetch  (fetch_i),
    .sel    (sel),
    .pabort (pabort_o),
    .dabort (dabort_o)
  );

  assign sel_o  = sel;
  assign addr_o = xlat_addr;

  p_boot_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (remap_act && mode == MAP_BOOT) |-> (sel == SEL_BOOT && !pabort_o && !dabort_o));

  p_ram_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (remap_act && mode == MAP_RAM) |-> (sel == SEL_SRAM && !pabort_o && !dabort_o));

  p_no_remap_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !remap_act |-> (addr_o == addr_i));

  p_abort_nosel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pabort_o || dabort_o) |-> (sel == SEL_NONE));

  p_periph_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_i |-> (sel != SEL_PERA && sel != SEL_PERB));

  p_abort_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(pabort_o && dabort_o) && !(dabort_o && fetch_i));

endmodule

// File: tb/sim_vecmap_decoder.sv
module sim_vecmap_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [1:0]  mode_wdata = 2'b00;
  logic [31:0] addr_i = 32'h0;
  logic        fetch_i = 1'b0;
  logic [2:0]  sel_o;
  logic [31:0] addr_o;
  logic        pabort_o, dabort_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vecmap_decoder u0 (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .addr_i(addr_i), .fetch_i(fetch_i), .sel_o(sel_o), .addr_o(addr_o),
    .pabort_o(pabort_o), .dabort_o(dabort_o)
  );

  // select codes, as stated in the requirements
  localparam logic [2:0] S_NONE = 3'd0, S_FLASH = 3'd1, S_SRAM = 3'd2,
                         S_BOOT = 3'd3, S_PA = 3'd4, S_PB = 3'd5;

  task automatic probe(input string tag, input logic [31:0] a, input logic f,
                       input logic [2:0] es, input logic [31:0] ea,
                       input logic ep, input logic ed);
    @(negedge clk);
    addr_i  = a;
    fetch_i = f;
    #1;
    checks++;
    if (sel_o !== es || addr_o !== ea || pabort_o !== ep || dabort_o !== ed) begin
      errors++;
      $display("FAIL %s addr=%h fetch=%0d: got sel=%0d addr=%h pa=%0d da=%0d exp sel=%0d addr=%h pa=%0d da=%0d",
               tag, a, f, sel_o, addr_o, pabort_o, dabort_o, es, ea, ep, ed);
    end
    checks++;
    if (pabort_o && dabort_o) begin
      errors++;
      $display("FAIL R11 both aborts high: got pa=%0d da=%0d exp not both", pabort_o, dabort_o);
    end
  endtask

  task automatic write_mode(input logic [1:0] m);
    @(negedge clk);
    mode_we    = 1'b1;
    mode_wdata = m;
    @(negedge clk);
    mode_we    = 1'b0;
  endtask

  task automatic t_reset_state;   // R1
    probe("R1", 32'h0, 1'b1, S_BOOT, 32'h7FFF_E000, 1'b0, 1'b0);
  endtask

  task automatic t_boot_window;   // R2, R6
    probe("R2", 32'h3C, 1'b0, S_BOOT, 32'h7FFF_E03C, 1'b0, 1'b0);
    probe("R2", 32'h3F, 1'b1, S_BOOT, 32'h7FFF_E03F, 1'b0, 1'b0);
    probe("R6", 32'h40, 1'b1, S_FLASH, 32'h40, 1'b0, 1'b0);
  endtask

  task automatic t_reserved_write; // R5
    write_mode(2'b11);
    probe("R5", 32'h08, 1'b0, S_BOOT, 32'h7FFF_E008, 1'b0, 1'b0);
  endtask

  task automatic t_flash_mode;    // R3, R5
    write_mode(2'b01);
    probe("R3", 32'h1C, 1'b1, S_FLASH, 32'h1C, 1'b0, 1'b0);
    probe("R3", 32'h00, 1'b0, S_FLASH, 32'h00, 1'b0, 1'b0);
  endtask

  task automatic t_ram_mode;      // R4, R5, R6
    write_mode(2'b10);
    probe("R4", 32'h20, 1'b0, S_SRAM, 32'h4000_0020, 1'b0, 1'b0);
    probe("R6", 32'h7FFF_E010, 1'b1, S_BOOT, 32'h7FFF_E010, 1'b0, 1'b0);
    probe("R6", 32'h4000_0010, 1'b0, S_SRAM, 32'h4000_0010, 1'b0, 1'b0);
    write_mode(2'b11);
    probe("R5", 32'h04, 1'b1, S_SRAM, 32'h4000_0004, 1'b0, 1'b0);
  endtask

  task automatic t_regions;       // R7, R8
    probe("R7", 32'h0001_FFFF, 1'b0, S_FLASH, 32'h0001_FFFF, 1'b0, 1'b0);
    probe("R8", 32'h0002_0000, 1'b0, S_NONE, 32'h0002_0000, 1'b0, 1'b1);
    probe("R8", 32'h0002_0000, 1'b1, S_NONE, 32'h0002_0000, 1'b1, 1'b0);
    probe("R7", 32'h4000_3FFF, 1'b1, S_SRAM, 32'h4000_3FFF, 1'b0, 1'b0);
    probe("R8", 32'h4000_4000, 1'b0, S_NONE, 32'h4000_4000, 1'b0, 1'b1);
    probe("R8", 32'h7FFF_DFFF, 1'b1, S_NONE, 32'h7FFF_DFFF, 1'b1, 1'b0);
    probe("R7", 32'h7FFF_FFFF, 1'b0, S_BOOT, 32'h7FFF_FFFF, 1'b0, 1'b0);
    probe("R8", 32'h8000_0000, 1'b0, S_NONE, 32'h8000_0000, 1'b0, 1'b1);
    probe("R8", 32'hDFFF_FFFF, 1'b1, S_NONE, 32'hDFFF_FFFF, 1'b1, 1'b0);
    probe("R8", 32'hE020_0000, 1'b0, S_NONE, 32'hE020_0000, 1'b0, 1'b1);
  endtask

  task automatic t_peripherals;   // R7, R9, R10
    probe("R7", 32'hE000_C000, 1'b0, S_PA, 32'hE000_C000, 1'b0, 1'b0);
    probe("R9", 32'hE000_D124, 1'b0, S_PA, 32'hE000_D124, 1'b0, 1'b0);
    probe("R9", 32'hE000_4000, 1'b1, S_NONE, 32'hE000_4000, 1'b1, 1'b0);
    probe("R10", 32'hE001_8000, 1'b0, S_NONE, 32'hE001_8000, 1'b0, 1'b1);
    probe("R10", 32'hE001_8000, 1'b1, S_NONE, 32'hE001_8000, 1'b1, 1'b0);
    probe("R7", 32'hE005_C010, 1'b0, S_PA, 32'hE005_C010, 1'b0, 1'b0);
    probe("R7", 32'hFFFF_F000, 1'b0, S_PB, 32'hFFFF_F000, 1'b0, 1'b0);
    probe("R9", 32'hFFFF_FFFC, 1'b1, S_NONE, 32'hFFFF_FFFC, 1'b1, 1'b0);
    probe("R10", 32'hFFE0_0000, 1'b0, S_NONE, 32'hFFE0_0000, 1'b0, 1'b1);
  endtask

  task automatic t_reset_again;   // R1
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    probe("R1", 32'h18, 1'b0, S_BOOT, 32'h7FFF_E018, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_boot_window();
    t_reserved_write();
    t_flash_mode();
    t_ram_mode();
    t_regions();
    t_peripherals();
    t_reset_again();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got no completion exp completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule